// File: doc/BRIEF.md
# Board Configuration Transaction Controller

This block is a small memory-mapped engine that carries out one board-configuration transaction each time software sets the start bit of its control register. Three registers sit in a 4 KB window: a data register, a control register and a status register. A control word names a function, a site, a stack position, a device and a controller number, and says whether the transaction reads or writes.

When a start is accepted, the engine spends one cycle deciding whether the target is valid and carrying it out. It reads or writes an internal table of oscillator frequencies, reads a fixed voltage-sensor value, or raises a one-cycle shutdown or reboot request. Completion and error are reported in the status register, never as a bus fault. The motherboard holds six oscillator entries. The daughterboard oscillator count, its reset values and the daughterboard sensor values are all parameters.

The register port is a valid/ready request channel with a response channel that cannot be stalled. A request transfers on a cycle where both `req_valid` and `req_ready` are high. `req_ready` drops for exactly the one cycle after a start is accepted, and a master must hold its request until it is accepted. An accepted read returns `rsp_valid` with `rsp_data` on the following cycle, and that response cannot be back-pressured.

Top module: `cfgx_ctrl`

## Requirements
- R1: The data register is at offset 0xA0 and keeps any 32-bit write. The control register at 0xA4 reads back the last written word with bit 31 and bits 19:18 forced to zero.
- R2: A write to the status register at 0xA8 keeps only bits 1:0. All upper status bits read as zero.
- R3: A control write with bit 31 set starts one transaction. `req_ready` is low for exactly the next cycle. Afterwards, status bit 0 (complete) is 1 and status bit 1 (error) reflects the outcome. A control write with bit 31 clear starts nothing.
- R4: A transaction is rejected with status 3 when any of these holds: control bits 29:26 (controller number) are nonzero, bits 15:12 (position) are nonzero, or bits 17:16 (site) are neither 0 (motherboard) nor 1 (daughterboard). A rejected transaction leaves the data register and the tables unchanged.
- R5: An oscillator read uses function code 1 (bits 25:20) with bit 30 = 0. It copies the entry selected by bits 11:0 into the data register. The motherboard entries 0 to 5 reset to 50 000 000, 23 750 000 and then 24 000 000 for the other four. Daughterboard entries reset to their parameter values.
- R6: An oscillator write (bit 30 = 1) stores the data register into the selected entry. A device number at or beyond the table size gives status 3.
- R7: A voltage read (function 2) returns the motherboard value for site 0 device 0. For site 1 it returns the daughterboard sensor value when the device number is below the sensor count. Any other voltage access, including any voltage write, gives status 3.
- R8: A write with function 8 (shutdown) or 9 (reboot) to site 0 device 0 gives a one-cycle pulse on `shutdown_req` or `reboot_req`. The pulse appears in the cycle right after the busy cycle. Any other form of these functions gives status 3 and no pulse.
- R9: Function 7 (video source select) and function 11 (display mode select) succeed only as writes to site 0 device 0, with no other effect. Any other form of these functions gives status 3.
- R10: Any function code other than 1, 2, 7, 8, 9 and 11 gives status 3.
- R11: An accepted read returns `rsp_valid` high for one cycle on the next cycle. Offsets other than the three registers read as zero and ignore writes.
- R12: After reset the data, control and status registers read zero, `req_ready` is high and both request pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted; low during the busy cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after an accepted read) |
| rsp_data | output | 32 | Read data |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench builds the block with three daughterboard oscillators and two daughterboard sensors. With that mix, device 2 is a valid oscillator but an invalid sensor, and device 3 falls outside both tables. This places the range boundaries of R6 and R7 on either side of one device number. The daughterboard oscillator and sensor values are chosen distinct from the motherboard ones, so a read routed to the wrong site or entry shows up as a wrong value.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned AW    = 12;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEV_W = 12;
  localparam int unsigned FN_W  = 6;
  localparam int unsigned MB_OSC_N = 6;

  localparam logic [AW-1:0] OFS_DATA = 12'h0A0;
  localparam logic [AW-1:0] OFS_CTRL = 12'h0A4;
  localparam logic [AW-1:0] OFS_STAT = 12'h0A8;

  // bits kept when the control register is written (start and 19:18 dropped)
  localparam logic [DW-1:0] CTRL_KEEP = ~32'h800C_0000;

  localparam logic [FN_W-1:0] FN_OSC  = 6'd1;
  localparam logic [FN_W-1:0] FN_VOLT = 6'd2;
  localparam logic [FN_W-1:0] FN_VMUX = 6'd7;
  localparam logic [FN_W-1:0] FN_SHUT = 6'd8;
  localparam logic [FN_W-1:0] FN_BOOT = 6'd9;
  localparam logic [FN_W-1:0] FN_DISP = 6'd11;

  localparam logic [1:0] SITE_MB = 2'd0;
  localparam logic [1:0] SITE_DB = 2'd1;

  localparam logic [MB_OSC_N*DW-1:0] MB_OSC_INIT = {
    32'd24_000_000, 32'd24_000_000, 32'd24_000_000,
    32'd24_000_000, 32'd23_750_000, 32'd50_000_000};

  typedef struct packed {
    logic             start;
    logic             wr;
    logic [3:0]       ctl;
    logic [FN_W-1:0]  fn;
    logic [1:0]       rsvd;
    logic [1:0]       site;
    logic [3:0]       pos;
    logic [DEV_W-1:0] dev;
  } ctrl_t;

  typedef struct packed {
    logic ok;     // transaction accepted
    logic fetch;  // result goes into the data register
    logic store;  // data register goes into a table
    logic osc;    // oscillator table (else sensor)
    logic db;     // daughterboard side
    logic shut;
    logic boot;
  } verdict_t;
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int DB_OSC_N   = 2,
  parameter int DB_VSENS_N = 2
) (
  input  ctrl_t    cw,
  output verdict_t vd
);
  logic path_ok, on_mb, on_db, dev0;
  logic unused_bits;
  assign unused_bits = ^{cw.start, cw.rsvd};

  assign on_mb   = (cw.site == SITE_MB);
  assign on_db   = (cw.site == SITE_DB);
  assign dev0    = (cw.dev == '0);
  assign path_ok = (cw.ctl == '0) && (cw.pos == '0) && (on_mb || on_db);

  always_comb begin
    vd = '0;
    if (path_ok) begin
      unique case (cw.fn)
        FN_OSC: begin
          if (on_mb && int'(cw.dev) < int'(MB_OSC_N)) begin
            vd.ok = 1'b1; vd.osc = 1'b1;
          end else if (on_db && int'(cw.dev) < DB_OSC_N) begin
            vd.ok = 1'b1; vd.osc = 1'b1; vd.db = 1'b1;
          end
          vd.fetch = vd.ok & ~cw.wr;
          vd.store = vd.ok & cw.wr;
        end
        FN_VOLT: begin
          if (!cw.wr) begin
            if (on_db && int'(cw.dev) < DB_VSENS_N) begin
              vd.ok = 1'b1; vd.db = 1'b1;
            end else if (on_mb && dev0) begin
              vd.ok = 1'b1;
            end
          end
          vd.fetch = vd.ok;
        end
        FN_VMUX, FN_DISP: vd.ok = cw.wr && on_mb && dev0;
        FN_SHUT: begin
          vd.ok   = cw.wr && on_mb && dev0;
          vd.shut = vd.ok;
        end
        FN_BOOT: begin
          vd.ok   = cw.wr && on_mb && dev0;
          vd.boot = vd.ok;
        end
        default: vd = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
  import cfgx_pkg::*;
#(
  parameter int unsigned       N    = 1,
  parameter logic [N*DW-1:0]   INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DEV_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [N*DW-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= INIT[g*DW +: DW];
      else if (we && int'(idx) == g)     q <= wdata;
    end
    assign flat[g*DW +: DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(N); i++)
      if (int'(idx) == i) rdata = flat[i*DW +: DW];
  end
endmodule

// File: rtl/cfgx_sense_rom.sv
module cfgx_sense_rom
  import cfgx_pkg::*;
#(
  parameter int unsigned     N     = 1,
  parameter logic [N*DW-1:0] DB_UV = '0,
  parameter logic [DW-1:0]   MB_UV = '0
) (
  input  logic             on_db,
  input  logic [DEV_W-1:0] idx,
  output logic [DW-1:0]    uv
);
  always_comb begin
    uv = MB_UV;
    if (on_db) begin
      uv = '0;
      for (int i = 0; i < int'(N); i++)
        if (int'(idx) == i) uv = DB_UV[i*DW +: DW];
    end
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int                         DB_OSC_N    = 2,
  parameter int                         DB_VSENS_N  = 2,
  parameter logic [DB_OSC_N*DW-1:0]     DB_OSC_INIT = {32'd30_000_000, 32'd45_000_000},
  parameter logic [DB_VSENS_N*DW-1:0]   DB_VOLT_UV  = {32'd1_200_000, 32'd1_000_000},
  parameter logic [DW-1:0]              MB_VOLT_UV  = 32'd3_300_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          shutdown_req,
  output logic          reboot_req
);
  logic [DW-1:0] data_q, ctrl_q;
  logic [1:0]    stat_q;
  logic          busy_q, shut_q, boot_q;
  logic          acc;
  ctrl_t         cw;
  verdict_t      vd;
  logic [DW-1:0] mb_rd, db_rd, uv_rd, fetched, rd_mux;
  logic          mb_we, db_we;

  assign req_ready    = ~busy_q;
  assign acc          = req_valid & ~busy_q;
  assign cw           = ctrl_q;
  assign shutdown_req = shut_q;
  assign reboot_req   = boot_q;

  cfgx_decode #(.DB_OSC_N(DB_OSC_N), .DB_VSENS_N(DB_VSENS_N)) u_dec (
    .cw(cw), .vd(vd));

  assign mb_we = busy_q & vd.ok & vd.store & vd.osc & ~vd.db;
  assign db_we = busy_q & vd.ok & vd.store & vd.osc &  vd.db;

  cfgx_osc_bank #(.N(MB_OSC_N), .INIT(MB_OSC_INIT)) u_mb_osc (
    .clk(clk), .rst_n(rst_n), .we(mb_we), .idx(cw.dev),
    .wdata(data_q), .rdata(mb_rd));

  cfgx_osc_bank #(.N(DB_OSC_N), .INIT(DB_OSC_INIT)) u_db_osc (
    .clk(clk), .rst_n(rst_n), .we(db_we), .idx(cw.dev),
    .wdata(data_q), .rdata(db_rd));

  cfgx_sense_rom #(.N(DB_VSENS_N), .DB_UV(DB_VOLT_UV), .MB_UV(MB_VOLT_UV)) u_sense (
    .on_db(vd.db), .idx(cw.dev), .uv(uv_rd));

  assign fetched = vd.osc ? (vd.db ? db_rd : mb_rd) : uv_rd;

  always_comb begin
    unique case (req_addr)
      OFS_DATA: rd_mux = data_q;
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_STAT: rd_mux = {{(DW-2){1'b0}}, stat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctrl_q    <= '0;
      stat_q    <= '0;
      busy_q    <= 1'b0;
      shut_q    <= 1'b0;
      boot_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc & ~req_write;
      shut_q    <= 1'b0;
      boot_q    <= 1'b0;
      if (acc && !req_write) rsp_data <= rd_mux;
      if (acc && req_write) begin
        unique case (req_addr)
          OFS_DATA: data_q <= req_wdata;
          OFS_CTRL: begin
            ctrl_q <= req_wdata & CTRL_KEEP;
            busy_q <= req_wdata[DW-1];
          end
          OFS_STAT: stat_q <= req_wdata[1:0];
          default: ;
        endcase
      end
      if (busy_q) begin
        busy_q <= 1'b0;
        stat_q <= {~vd.ok, 1'b1};
        if (vd.ok && vd.fetch) data_q <= fetched;
        shut_q <= vd.shut;
        boot_q <= vd.boot;
      end
    end
  end
endmodule

// File: rtl/cfgx_ctrl_chk.sv
module cfgx_ctrl_chk
  import cfgx_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          shutdown_req,
  input logic          reboot_req
);
  logic start_acc, read_acc;
  assign start_acc = req_valid && req_ready && req_write &&
                     req_addr == OFS_CTRL && req_wdata[DW-1];
  assign read_acc  = req_valid && req_ready && !req_write;

  p_start_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !req_ready);
  p_busy_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    read_acc |=> rsp_valid);
  p_rsp_only_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !read_acc |=> !rsp_valid);
  p_pulse_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> $past(!req_ready));
  p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reboot_req}));
  p_shut_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  p_boot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);
endmodule

bind cfgx_ctrl cfgx_ctrl_chk u_chk (.*);

// File: tb/sim_cfgx_ctrl.sv
module sim_cfgx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, shutdown_req, reboot_req;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0, cyc = 0;
  bit run = 0, done = 0;
  logic exp_ready = 1'b1, exp_rsp = 1'b0, exp_shut = 1'b0, exp_boot = 1'b0;

  // behavioural model state
  logic [31:0] m_data = 0, m_ctrl = 0, m_stat = 0;
  logic [31:0] m_mb [6] = '{32'd50000000, 32'd23750000, 32'd24000000,
                            32'd24000000, 32'd24000000, 32'd24000000};
  logic [31:0] m_db [3] = '{32'd60000000, 32'd40000000, 32'd33000000};
  logic [31:0] m_uv [2] = '{32'd900000, 32'd1000000};

  always #4 clk = ~clk;

  cfgx_ctrl #(
    .DB_OSC_N(3), .DB_VSENS_N(2),
    .DB_OSC_INIT({32'd33000000, 32'd40000000, 32'd60000000}),
    .DB_VOLT_UV({32'd1000000, 32'd900000}),
    .MB_VOLT_UV(32'd3300000)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of handshake and pulse outputs with the model
  always @(negedge clk) begin
    if (run && !done) begin
      #1;
      chk("R3 req_ready", {31'd0, req_ready}, {31'd0, exp_ready});
      chk("R11 rsp_valid", {31'd0, rsp_valid}, {31'd0, exp_rsp});
      chk("R8 shutdown_req", {31'd0, shutdown_req}, {31'd0, exp_shut});
      chk("R8 reboot_req", {31'd0, reboot_req}, {31'd0, exp_boot});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic model_exec(output logic sh, output logic bt);
    logic [3:0]  ctl  = m_ctrl[29:26];
    logic [5:0]  fn   = m_ctrl[25:20];
    logic [1:0]  site = m_ctrl[17:16];
    logic [3:0]  pos  = m_ctrl[15:12];
    int          dev  = int'(m_ctrl[11:0]);
    logic        w    = m_ctrl[30];
    logic        good = 0;
    logic [31:0] val  = 0;
    sh = 0; bt = 0;
    if (ctl == 0 && pos == 0 && site < 2) begin
      if (fn == 1) begin
        if (site == 0 && dev < 6) begin
          good = 1; if (w) m_mb[dev] = m_data; else val = m_mb[dev];
        end else if (site == 1 && dev < 3) begin
          good = 1; if (w) m_db[dev] = m_data; else val = m_db[dev];
        end
      end else if (fn == 2 && !w) begin
        if (site == 0 && dev == 0) begin good = 1; val = 32'd3300000; end
        else if (site == 1 && dev < 2) begin good = 1; val = m_uv[dev]; end
      end else if (w && site == 0 && dev == 0 &&
                   (fn == 7 || fn == 8 || fn == 9 || fn == 11)) begin
        good = 1; sh = (fn == 8); bt = (fn == 9);
      end
    end
    if (good && !w) m_data = val;
    m_stat = good ? 32'd1 : 32'd3;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic sh, bt, st;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    st = 0;
    case (a)
      12'h0A0: m_data = d;
      12'h0A4: begin m_ctrl = d & 32'h7FF3FFFF; st = d[31]; end
      12'h0A8: m_stat = d & 32'd3;
      default: ;
    endcase
    if (st) begin
      exp_ready = 0;
      @(negedge clk);
      model_exec(sh, bt);
      exp_ready = 1; exp_shut = sh; exp_boot = bt;
      @(negedge clk);
      exp_shut = 0; exp_boot = 0;
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    exp_rsp = 1;
    case (a)
      12'h0A0: e = m_data;
      12'h0A4: e = m_ctrl;
      12'h0A8: e = m_stat;
      default: e = 0;
    endcase
    chk(tag, rsp_data, e);
    @(negedge clk);
    exp_rsp = 0;
  endtask

  function automatic logic [31:0] cw(input logic w, input logic [5:0] fn, input logic [1:0] site,
                                     input logic [11:0] dev, input logic [3:0] pos = 0,
                                     input logic [3:0] ctl = 0);
    return {1'b1, w, ctl, fn, 2'b00, site, pos, dev};
  endfunction

  task automatic txn(input logic [31:0] word, input string tag);
    wr(12'h0A4, word);
    rd(12'h0A8, tag);
    rd(12'h0A0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; run = 1;
    @(negedge clk);
    // R12 reset state
    rd(12'h0A0, "R12 data reset");
    rd(12'h0A4, "R12 ctrl reset");
    rd(12'h0A8, "R12 status reset");
    // R5 oscillator reads, both boards
    for (int i = 0; i < 6; i++) txn(cw(0, 1, 0, 12'(i)), "R5 mb osc read");
    for (int i = 0; i < 3; i++) txn(cw(0, 1, 1, 12'(i)), "R5 db osc read");
    // R6 oscillator writes and range
    wr(12'h0A0, 32'h1234_5678); txn(cw(1, 1, 0, 3), "R6 mb osc write");
    txn(cw(0, 1, 0, 3), "R6 mb osc readback");
    wr(12'h0A0, 32'h0BAD_F00D); txn(cw(1, 1, 1, 2), "R6 db osc write");
    txn(cw(0, 1, 1, 2), "R6 db osc readback");
    txn(cw(0, 1, 0, 6), "R6 mb osc out of range");
    txn(cw(1, 1, 1, 3), "R6 db osc write out of range");
    txn(cw(0, 1, 1, 3), "R6 db osc read out of range");
    // R7 voltages
    txn(cw(0, 2, 0, 0), "R7 mb volt");
    txn(cw(0, 2, 0, 1), "R7 mb volt dev1");
    txn(cw(0, 2, 1, 0), "R7 db volt 0");
    txn(cw(0, 2, 1, 1), "R7 db volt 1");
    txn(cw(0, 2, 1, 2), "R7 db volt past count");
    txn(cw(1, 2, 0, 0), "R7 volt write");
    // R4 target checks
    txn(cw(0, 1, 0, 0, 0, 1), "R4 nonzero controller");
    txn(cw(0, 1, 0, 0, 1, 0), "R4 nonzero position");
    txn(cw(0, 1, 2, 0), "R4 site 2");
    txn(cw(0, 1, 3, 0), "R4 site 3");
    // R8 shutdown / reboot
    txn(cw(1, 8, 0, 0), "R8 shutdown");
    txn(cw(0, 8, 0, 0), "R8 shutdown as read");
    txn(cw(1, 9, 0, 0), "R8 reboot");
    txn(cw(1, 9, 1, 0), "R8 reboot db site");
    txn(cw(1, 8, 0, 5), "R8 shutdown dev5");
    // R9 video select / display mode
    txn(cw(1, 7, 0, 0), "R9 video select");
    txn(cw(1, 11, 0, 0), "R9 display mode");
    txn(cw(1, 7, 0, 1), "R9 video select dev1");
    txn(cw(0, 11, 0, 0), "R9 display mode read");
    // R10 unknown function codes
    txn(cw(0, 0, 0, 0), "R10 fn 0");
    txn(cw(1, 3, 0, 0), "R10 fn 3");
    txn(cw(1, 63, 0, 0), "R10 fn 63");
    // R2 status write
    wr(12'h0A8, 32'hFFFF_FFFF); rd(12'h0A8, "R2 status all ones");
    wr(12'h0A8, 32'h0000_0002); rd(12'h0A8, "R2 status error only");
    // R1 / R3 control without start, then all ones with start
    wr(12'h0A0, 32'hCAFE_0001); rd(12'h0A0, "R1 data register");
    wr(12'h0A4, 32'h7FFF_FFFF); rd(12'h0A4, "R1 ctrl masked");
    rd(12'h0A8, "R3 no start no status change");
    wr(12'h0A4, 32'hFFFF_FFFF); rd(12'h0A4, "R1 ctrl start reads zero");
    rd(12'h0A8, "R3 start status");
    // R11 unmapped offsets
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h0AC, 32'hFFFF_FFFF);
    rd(12'h000, "R11 unmapped 0x000");
    rd(12'h0AC, "R11 unmapped 0x0AC");
    rd(12'h0A0, "R11 data untouched");
    rd(12'h0A8, "R11 status untouched");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule